// File: doc/BRIEF.md
# Virtual Processor Pending Priority Bitmap

This block holds, for each virtual processor entry, an 8-bit map of pending interrupt priorities, one bit per priority level. Software reaches it through a memory-mapped data port. The address carries the whole command: the page number selects the entry, and the offset within the page selects both the operation and the priority level. A single access can set the bit for one priority, clear it, or only inspect it. Every load returns the value that bit had before the access took effect.

Only even pages map onto virtual processor entries. The entry index is the page number divided by two. Odd pages belong to other logic and appear here as missing entries. A separate configuration port writes a whole bitmap and the valid flag of one entry in a single cycle. Firmware uses it to prepare the table.

Top module: `vp_pend_bitmap`

## Requirements
- R1: Address decode. The page number is req_addr[ADDR_W-1:12]. Bits [11:10] give the operation code and bits [6:4] give the priority. Only even pages reach an entry, with index equal to the page number shifted right by one. An odd page, or an index at or above NUM_ENTRIES, counts as a missing entry.
- R2: Operation 00 sets the bit for the addressed priority. Priority p is stored in bitmap bit 7-p, so priority 0 is the most significant bit. Setting a bit that is already set leaves it set.
- R3: Operation 01 clears the bit for the addressed priority. Clearing a bit that is already clear leaves it clear.
- R4: Operations 10 and 11 leave the bitmap unchanged.
- R5: A load has rsp_valid high in the cycle after the request. Its rsp_data is 16'h0001 when the addressed bit was set before the access, and 16'h0000 when it was not. A store produces no response, and the store data has no effect on the result.
- R6: A load is accepted only with req_size 2 and a store only with req_size 1. A load of any other size returns 16'hFFFF and changes nothing. A store of any other size changes nothing.
- R7: An access to a missing entry, or to an entry whose valid flag is clear, changes no state. A load of this kind returns 16'hFFFF.
- R8: A configuration write loads cfg_bitmap and cfg_valid into entry cfg_idx at the next clock edge.
- R9: When a configuration write and a data-port access hit the same entry in the same cycle, the entry takes the configuration value. The load response still reports the state from before that edge.
- R10: After reset, every entry is invalid with an all-zero bitmap, and rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Data-port access request |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 4 | Access size in bytes |
| req_addr | input | ADDR_W | Access address (page, operation, priority) |
| req_wdata | input | 8 | Store data (has no effect on state) |
| rsp_valid | output | 1 | Load response valid |
| rsp_data | output | 16 | Prior bit state, or all ones on error |
| cfg_we | input | 1 | Configuration write enable |
| cfg_idx | input | IDX_W | Entry index for the configuration write |
| cfg_bitmap | input | 8 | Bitmap value to load |
| cfg_valid | input | 1 | Valid flag value to load |

## Verification
Two functions can fall in the same cycle: a configuration write and a data-port set or clear, both aimed at one entry. The bench provokes this by raising cfg_we in the same cycle as a load. The load's command is chosen to flip a bit, while the configuration carries a bitmap that disagrees with that flip. The bench then judges three things: the load response must match the bitmap from before the edge, every priority read back afterwards must match the configured value, and a collision on two different entries must apply both writes.

// File: rtl/vpb_pkg.sv
package vpb_pkg;
  typedef enum logic [1:0] {
    OP_SET   = 2'b00,
    OP_CLR   = 2'b01,
    OP_PEEK0 = 2'b10,
    OP_PEEK1 = 2'b11
  } vpb_op_e;

  localparam int unsigned BM_W       = 8;
  localparam int unsigned RSP_W      = 16;
  localparam int unsigned PAGE_SHIFT = 12;
  localparam logic [RSP_W-1:0] RSP_ERR = '1;

  function automatic logic [BM_W-1:0] prio_mask(input logic [2:0] prio);
    prio_mask = 8'h80 >> prio;
  endfunction
endpackage

// File: rtl/vpb_decode.sv
module vpb_decode
  import vpb_pkg::*;
#(
  parameter int unsigned ADDR_W      = 20,
  parameter int unsigned NUM_ENTRIES = 16,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES),
  localparam int unsigned FULL_IDX_W = ADDR_W - PAGE_SHIFT - 1
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [3:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              acc_ok,
  output logic              is_load,
  output vpb_op_e           op,
  output logic [2:0]        prio,
  output logic [IDX_W-1:0]  idx
);
  logic                  size_ok;
  logic                  even_page;
  logic                  in_range;
  logic [FULL_IDX_W-1:0] full_idx;
  logic [12:0]           unused_addr;

  assign unused_addr = {req_addr[12], req_addr[9:7], req_addr[3:0], 5'd0};

  always_comb begin
    is_load   = req_valid & ~req_write;
    size_ok   = req_write ? (req_size == 4'd1) : (req_size == 4'd2);
    even_page = ~req_addr[PAGE_SHIFT];
    full_idx  = req_addr[ADDR_W-1:PAGE_SHIFT+1];
    in_range  = (32'(full_idx) < NUM_ENTRIES);
    acc_ok    = req_valid & size_ok & even_page & in_range;
    op        = vpb_op_e'(req_addr[11:10]);
    prio      = req_addr[6:4];
    idx       = full_idx[IDX_W-1:0];
  end
endmodule

// File: rtl/vpb_store.sv
module vpb_store
  import vpb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        upd_en,
  input  logic [IDX_W-1:0]            upd_idx,
  input  logic                        upd_set,
  input  logic [BM_W-1:0]             upd_mask,
  input  logic                        cfg_we,
  input  logic [IDX_W-1:0]            cfg_idx,
  input  logic [BM_W-1:0]             cfg_bitmap,
  input  logic                        cfg_valid,
  output logic [NUM_ENTRIES*BM_W-1:0] bitmap_flat,
  output logic [NUM_ENTRIES-1:0]      valid_vec
);
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    logic [BM_W-1:0] bm_q, bm_d;
    logic            vld_q, vld_d;
    logic            cfg_hit, upd_hit, en;

    always_comb begin
      cfg_hit = cfg_we & (cfg_idx == IDX_W'(g));
      upd_hit = upd_en & (upd_idx == IDX_W'(g));
      en      = cfg_hit | upd_hit;
      bm_d    = bm_q;
      vld_d   = vld_q;
      if (cfg_hit) begin
        bm_d  = cfg_bitmap;
        vld_d = cfg_valid;
      end else if (upd_hit) begin
        bm_d  = upd_set ? (bm_q | upd_mask) : (bm_q & ~upd_mask);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bm_q  <= '0;
        vld_q <= 1'b0;
      end else if (en) begin
        bm_q  <= bm_d;
        vld_q <= vld_d;
      end
    end

    assign bitmap_flat[g*BM_W +: BM_W] = bm_q;
    assign valid_vec[g]                = vld_q;
  end
endmodule

// File: rtl/vp_pend_bitmap.sv
module vp_pend_bitmap
  import vpb_pkg::*;
#(
  parameter int unsigned ADDR_W      = 20,
  parameter int unsigned NUM_ENTRIES = 16,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [3:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  output logic [15:0]       rsp_data,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [7:0]        cfg_bitmap,
  input  logic              cfg_valid
);
  logic                        acc_ok, is_load;
  vpb_op_e                     op;
  logic [2:0]                  prio;
  logic [IDX_W-1:0]            idx;
  logic [NUM_ENTRIES*BM_W-1:0] bitmap_flat;
  logic [NUM_ENTRIES-1:0]      valid_vec;
  logic [BM_W-1:0]             cur_bm, mask;
  logic                        live, upd_en, prior_bit;
  logic                        rsp_valid_q, rsp_valid_d;
  logic [RSP_W-1:0]            rsp_data_q, rsp_data_d;
  logic [7:0]                  unused_wdata;

  assign unused_wdata = req_wdata;

  vpb_decode #(.ADDR_W(ADDR_W), .NUM_ENTRIES(NUM_ENTRIES)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .acc_ok    (acc_ok),
    .is_load   (is_load),
    .op        (op),
    .prio      (prio),
    .idx       (idx)
  );

  always_comb begin
    cur_bm    = bitmap_flat[idx*BM_W +: BM_W];
    mask      = prio_mask(prio);
    live      = acc_ok & valid_vec[idx];
    upd_en    = live & ~op[1];
    prior_bit = |(cur_bm & mask);
  end

  vpb_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_en      (upd_en),
    .upd_idx     (idx),
    .upd_set     (op == OP_SET),
    .upd_mask    (mask),
    .cfg_we      (cfg_we),
    .cfg_idx     (cfg_idx),
    .cfg_bitmap  (cfg_bitmap),
    .cfg_valid   (cfg_valid),
    .bitmap_flat (bitmap_flat),
    .valid_vec   (valid_vec)
  );

  always_comb begin
    rsp_valid_d = is_load;
    rsp_data_d  = rsp_data_q;
    if (is_load) begin
      rsp_data_d = live ? RSP_W'(prior_bit) : RSP_ERR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      if (is_load) rsp_data_q <= rsp_data_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/vpb_checker.sv
module vpb_checker #(
  parameter int unsigned ADDR_W      = 20,
  parameter int unsigned NUM_ENTRIES = 16,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_write,
  input logic [3:0]                req_size,
  input logic [ADDR_W-1:0]         req_addr,
  input logic                      rsp_valid,
  input logic [15:0]               rsp_data,
  input logic                      cfg_we,
  input logic [IDX_W-1:0]          cfg_idx,
  input logic [7:0]                cfg_bitmap,
  input logic [NUM_ENTRIES*8-1:0]  bitmap_flat
);
  AST_RSP_FOR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid && !req_write)); // R5

  AST_RSP_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_data == 16'hFFFF || rsp_data <= 16'd1)); // R5

  AST_BAD_LOAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && !req_write && req_size != 4'd2) |-> rsp_data == 16'hFFFF); // R6

  AST_BAD_STORE_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_write && req_size != 4'd1 && !cfg_we) |-> $stable(bitmap_flat)); // R6

  AST_ODD_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && !req_write && req_addr[12]) |-> rsp_data == 16'hFFFF); // R1

  AST_CFG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we) |-> bitmap_flat[int'($past(cfg_idx))*8 +: 8] == $past(cfg_bitmap)); // R9
endmodule

bind vp_pend_bitmap vpb_checker #(.ADDR_W(ADDR_W), .NUM_ENTRIES(NUM_ENTRIES)) u_vpb_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_size    (req_size),
  .req_addr    (req_addr),
  .rsp_valid   (rsp_valid),
  .rsp_data    (rsp_data),
  .cfg_we      (cfg_we),
  .cfg_idx     (cfg_idx),
  .cfg_bitmap  (cfg_bitmap),
  .bitmap_flat (bitmap_flat)
);

// File: tb/test_vp_pend_bitmap.sv
module test_vp_pend_bitmap;
  localparam int ADDR_W = 20;
  localparam int NE     = 16;
  localparam int IW     = $clog2(NE);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_write;
  logic [3:0]        req_size;
  logic [ADDR_W-1:0] req_addr;
  logic [7:0]        req_wdata;
  logic              rsp_valid;
  logic [15:0]       rsp_data;
  logic              cfg_we, cfg_valid;
  logic [IW-1:0]     cfg_idx;
  logic [7:0]        cfg_bitmap;

  int checks = 0;
  int failures = 0;
  logic [7:0] m_bm [NE];
  logic       m_vld [NE];

  always #10 clk = ~clk;

  vp_pend_bitmap #(.ADDR_W(ADDR_W), .NUM_ENTRIES(NE)) i_vp_pend_bitmap (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_bitmap(cfg_bitmap), .cfg_valid(cfg_valid)
  );

  function automatic logic [ADDR_W-1:0] mk(int page, int op, int prio);
    mk = ADDR_W'((page << 12) | (op << 10) | (prio << 4));
  endfunction

  task automatic check(string tag, logic [16:0] act, logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected response and model update for one access (cfg applied afterwards)
  function automatic logic [15:0] model(logic wr, int sz, int page, int op, int prio);
    int  ix = page >> 1;
    logic ok = (wr ? sz == 1 : sz == 2) && (page % 2 == 0) && ix < NE;
    logic [7:0] msk = 8'h80 >> prio;
    logic [15:0] r;
    if (!ok || !m_vld[ix]) return 16'hFFFF;
    r = {15'd0, |(m_bm[ix] & msk)};
    if (op == 0) m_bm[ix] = m_bm[ix] | msk;
    else if (op == 1) m_bm[ix] = m_bm[ix] & ~msk;
    return r;
  endfunction

  task automatic access(string tag, logic wr, int sz, int page, int op, int prio,
                        logic [7:0] wd, logic do_cfg = 0, int ci = 0,
                        logic [7:0] cb = 0, logic cv = 0);
    logic [15:0] exp;
    @(negedge clk);
    exp = model(wr, sz, page, op, prio);
    if (do_cfg) begin m_bm[ci] = cb; m_vld[ci] = cv; end
    req_valid = 1; req_write = wr; req_size = 4'(sz);
    req_addr = mk(page, op, prio); req_wdata = wd;
    cfg_we = do_cfg; cfg_idx = IW'(ci); cfg_bitmap = cb; cfg_valid = cv;
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    if (!wr) check(tag, {rsp_valid, rsp_data}, {1'b1, exp});
    else     check(tag, {16'd0, rsp_valid}, 17'd0);
  endtask

  task automatic cfg(int ci, logic [7:0] cb, logic cv);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IW'(ci); cfg_bitmap = cb; cfg_valid = cv;
    m_bm[ci] = cb; m_vld[ci] = cv;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic read_all(string tag, int ix);
    for (int p = 0; p < 8; p++) access(tag, 0, 2, ix * 2, 2 + (p % 2), p, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1));
    for (int i = 0; i < NE; i++) begin m_bm[i] = 0; m_vld[i] = 0; end
    req_valid = 0; req_write = 0; req_size = 0; req_addr = 0; req_wdata = 0;
    cfg_we = 0; cfg_idx = 0; cfg_bitmap = 0; cfg_valid = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R10 rsp_valid after reset", {16'd0, rsp_valid}, 17'd0);
    access("R10 entry invalid after reset", 0, 2, 6, 2, 1, 0);

    cfg(3, 8'h80, 1);                       // R8 load bitmap
    access("R8 R2 prio0 is msb", 0, 2, 6, 2, 0, 0);
    access("R2 prio7 is lsb clear", 0, 2, 6, 3, 7, 0);
    access("R2 store set prio2", 1, 1, 6, 0, 2, 8'h07);
    access("R2 load set again returns 1", 0, 2, 6, 0, 2, 0);
    access("R3 load clear returns 1", 0, 2, 6, 1, 2, 0);
    access("R3 store clear again", 1, 1, 6, 1, 2, 8'hFF);
    access("R3 R4 read after clear", 0, 2, 6, 2, 2, 0);
    read_all("R4 peek leaves state", 3);
    access("R6 load size 8", 0, 8, 6, 2, 0, 0);
    access("R6 load size 1 with set op", 0, 1, 6, 0, 5, 0);
    access("R6 store size 2 ignored", 1, 2, 6, 0, 6, 0);
    access("R6 store size 4 ignored", 1, 4, 6, 1, 0, 0);
    read_all("R6 state unchanged", 3);
    access("R1 odd page missing", 0, 2, 7, 2, 0, 0);
    access("R1 odd page store ignored", 1, 1, 7, 1, 0, 0);
    access("R7 index out of range", 0, 2, NE * 2, 2, 0, 0);
    cfg(5, 8'hFF, 0);
    access("R7 invalid entry load", 0, 2, 10, 1, 0, 0);
    access("R7 invalid entry store", 1, 1, 10, 1, 0, 0);
    cfg(5, m_bm[5], 1);
    read_all("R7 invalid entry unchanged", 5);
    // R9: collision on the same entry, cfg wins, response is pre-edge state
    cfg(4, 8'h00, 1);
    access("R9 collide same entry rsp", 0, 2, 8, 0, 1, 0, 1, 4, 8'h0F, 1);
    read_all("R9 cfg value kept", 4);
    access("R9 collide other entry", 0, 2, 8, 0, 0, 0, 1, 9, 8'hA5, 1);
    read_all("R9 both writes applied", 4);
    read_all("R9 other entry cfg", 9);

    for (int n = 0; n < 600; n++) begin
      int  k  = int'($urandom_range(0, 19));
      int  pg = (k < 16) ? int'($urandom_range(0, 2 * NE - 1)) : int'($urandom_range(0, 2 * NE + 5));
      logic wr = 1'($urandom_range(0, 1));
      int  sz = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 8)) : (wr ? 1 : 2);
      int  op = int'($urandom_range(0, 3));
      int  pr = int'($urandom_range(0, 7));
      if (k == 19) cfg(int'($urandom_range(0, NE - 1)), 8'($urandom), 1'($urandom_range(0, 3) != 0));
      else if (k == 18)
        access("R9 random collision", 0, 2, pg % (2 * NE), op, pr, 0, 1,
               (pg % (2 * NE)) >> 1, 8'($urandom), 1);
      else access("R5 random access", wr, sz, pg, op, pr, 8'($urandom));
    end
    for (int i = 0; i < NE; i++) if (m_vld[i]) read_all("R5 final state", i);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule